// File: doc/BRIEF.md
# Interleaved Multi-Port Cache Lookup Arbiter

This block sits in front of an instruction cache's lookup pipeline. It holds a small queue of pending read requests and, every cycle, issues up to `NPORTS` of them to the cache's read ports. Two requests may share a cycle only if their conflict keys differ. The key is chosen by a parameter: a bank number in bank-interleaved mode, or the low bits of the set index in set-interleaved mode. A fetch that crosses a word or line boundary can be split by the requester into two requests. These are accepted in one cycle and, when their keys differ, looked up together.

The requester never sees the interleaving choice. It offers up to `NPORTS` requests whenever `in_ready` is high and then waits for the cache's answers. The queue is scanned oldest first. The oldest entry is always issued. A younger entry is issued only when its key clashes with nothing already picked in that cycle. Entries left behind keep their age order.

A three-state controller tracks occupancy. `ST_IDLE` means the queue is empty. `ST_RUN` means it holds entries and has room for a full group of `NPORTS`. `ST_FULL` means it has fewer than `NPORTS` free slots. The transitions are named as follows:
- fill: `ST_IDLE`→`ST_RUN`
- drain: `ST_RUN`→`ST_IDLE`
- clog: `ST_RUN`→`ST_FULL`
- relieve: `ST_FULL`→`ST_RUN`
- flush: `ST_FULL`→`ST_IDLE`
- jam: `ST_IDLE`→`ST_FULL`, reachable only for tiny depths

Top module: `lookup_arbiter`

## Requirements
- R1: After reset the queue is empty, `in_ready` is 1 and no lookup is valid. `in_ready` is 1 exactly when at least `NPORTS` queue slots are free. While it is 1, every asserted `in_valid` bit enqueues its address, lower lanes counting as older.
- R2: A request captured at a clock edge is visible on the lookup ports in the cycle that follows that edge. It leaves the queue at the next edge after it is shown valid.
- R3: Whenever the queue is not empty, lookup port 0 is valid and carries the oldest queued address.
- R4: At most `NPORTS` lookups are issued per cycle. Valid ports are contiguous from port 0 and appear in age order.
- R5: In bank mode the conflict key is `addr[WORD_OFF +: KEY_W]`. With the defaults (4-byte words, 4 ways) this is `addr[3:2]`, reported on `lk_key`.
- R6: In set mode the conflict key is `addr[LINE_OFF +: KEY_W]`. With the defaults (64-byte lines) this is `addr[7:6]`, reported on `lk_key`.
- R7: Lookups issued in the same cycle carry distinct keys. A younger request whose key matches an already chosen one waits. A still younger request with a free key may be issued past it.
- R8: Requests that wait keep their relative age order and are issued later without loss or duplication.
- R9: A two-request fetch that crosses a word or line boundary into a different key is issued on two ports in the same cycle.
- R10: The controller is in `ST_FULL` exactly when fewer than `NPORTS` slots are free, and in `ST_IDLE` exactly when the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | NPORTS | Per-lane request valid, lane 0 oldest |
| in_addr | input | NPORTS*ADDR_W | Per-lane request byte address |
| in_ready | output | 1 | Room for a full group of NPORTS requests |
| lk_valid | output | NPORTS | Per-port lookup issue |
| lk_addr | output | NPORTS*ADDR_W | Per-port lookup address, zero when idle |
| lk_key | output | NPORTS*KEY_W | Per-port bank or set-group key |

## Verification
Every result of this block is due one edge after its cause. A request driven before edge k appears on the lookup ports right after edge k. A conflicting younger request appears right after edge k+1. `in_ready` reflects the occupancy left by edge k. The bench drives inputs and samples outputs only on falling edges, so each check falls in the first half-cycle after the rising edge that produced the expected value. The expected ports, keys and occupancy come from a counting model of the queue together with the key bit fields.

// File: rtl/lkarb_pkg.sv
package lkarb_pkg;
    typedef enum logic [0:0] {
        ILV_BANK = 1'b0,
        ILV_SET  = 1'b1
    } ilv_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FULL = 2'd2
    } arb_state_e;
endpackage

// File: rtl/lkarb_keygen.sv
module lkarb_keygen #(
    parameter int                    ADDR_W   = 32,
    parameter int                    KEY_W    = 2,
    parameter int                    WORD_OFF = 2,
    parameter int                    LINE_OFF = 6,
    parameter lkarb_pkg::ilv_mode_e  MODE     = lkarb_pkg::ILV_BANK
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [KEY_W-1:0]  key
);
    generate
        if (MODE == lkarb_pkg::ILV_BANK) begin : g_bank
            // bank number sits just above the byte-in-word offset
            assign key = KEY_W'(addr >> WORD_OFF);
        end else begin : g_set
            // low set-index bits sit just above the line offset
            assign key = KEY_W'(addr >> LINE_OFF);
        end
    endgenerate
endmodule

// File: rtl/lkarb_queue.sv
module lkarb_queue #(
    parameter int ADDR_W = 32,
    parameter int NPORTS = 2,
    parameter int DEPTH  = 8,
    parameter int CNT_W  = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push_en,
    input  logic [NPORTS-1:0]             push_v,
    input  logic [NPORTS-1:0][ADDR_W-1:0] push_addr,
    input  logic [DEPTH-1:0]              take,
    output logic [DEPTH-1:0]              ent_v,
    output logic [DEPTH-1:0][ADDR_W-1:0]  ent_addr,
    output logic [CNT_W-1:0]              cnt,
    output logic [CNT_W-1:0]              cnt_nxt
);
    logic [DEPTH-1:0]             nxt_v;
    logic [DEPTH-1:0][ADDR_W-1:0] nxt_addr;
    int                           n;

    // survivors compact toward slot 0 in age order, new lanes append behind
    always_comb begin
        nxt_v    = '0;
        nxt_addr = '0;
        n        = 0;
        for (int i = 0; i < DEPTH; i++) begin
            if (ent_v[i] && !take[i]) begin
                for (int j = 0; j < DEPTH; j++) begin
                    if (j == n) begin
                        nxt_v[j]    = 1'b1;
                        nxt_addr[j] = ent_addr[i];
                    end
                end
                n = n + 1;
            end
        end
        for (int p = 0; p < NPORTS; p++) begin
            if (push_en && push_v[p]) begin
                for (int j = 0; j < DEPTH; j++) begin
                    if (j == n) begin
                        nxt_v[j]    = 1'b1;
                        nxt_addr[j] = push_addr[p];
                    end
                end
                n = n + 1;
            end
        end
        cnt_nxt = CNT_W'(n);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_v    <= '0;
            ent_addr <= '0;
            cnt      <= '0;
        end else begin
            ent_v    <= nxt_v;
            ent_addr <= nxt_addr;
            cnt      <= cnt_nxt;
        end
    end
endmodule

// File: rtl/lkarb_pick.sv
module lkarb_pick #(
    parameter int NPORTS = 2,
    parameter int DEPTH  = 8,
    parameter int KEY_W  = 2,
    parameter int IDX_W  = 3
) (
    input  logic                        en,
    input  logic [DEPTH-1:0]            vld,
    input  logic [DEPTH-1:0][KEY_W-1:0] keys,
    output logic [DEPTH-1:0]            take,
    output logic [NPORTS-1:0]           pv,
    output logic [NPORTS-1:0][IDX_W-1:0] pidx
);
    localparam int NKEYS = 1 << KEY_W;

    logic [NKEYS-1:0] used;
    int               k;

    // oldest-first scan; a key already claimed this cycle blocks younger entries
    always_comb begin
        used = '0;
        take = '0;
        pv   = '0;
        pidx = '0;
        k    = 0;
        for (int i = 0; i < DEPTH; i++) begin
            if (en && vld[i] && (k < NPORTS) && !used[keys[i]]) begin
                take[i]        = 1'b1;
                used[keys[i]]  = 1'b1;
                for (int p = 0; p < NPORTS; p++) begin
                    if (p == k) begin
                        pv[p]   = 1'b1;
                        pidx[p] = IDX_W'(i);
                    end
                end
                k = k + 1;
            end
        end
    end
endmodule

// File: rtl/lookup_arbiter.sv
module lookup_arbiter #(
    parameter int                    ADDR_W     = 32,
    parameter int                    NPORTS     = 2,
    parameter int                    NWAYS      = 4,
    parameter int                    DEPTH      = 8,
    parameter int                    WORD_BYTES = 4,
    parameter int                    LINE_BYTES = 64,
    parameter lkarb_pkg::ilv_mode_e  MODE       = lkarb_pkg::ILV_BANK
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NPORTS-1:0]          in_valid,
    input  logic [NPORTS*ADDR_W-1:0]   in_addr,
    output logic                       in_ready,
    output logic [NPORTS-1:0]          lk_valid,
    output logic [NPORTS*ADDR_W-1:0]   lk_addr,
    output logic [NPORTS*$clog2(NWAYS)-1:0] lk_key
);
    import lkarb_pkg::*;

    localparam int KEY_W    = $clog2(NWAYS);
    localparam int WORD_OFF = $clog2(WORD_BYTES);
    localparam int LINE_OFF = $clog2(LINE_BYTES);
    localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W    = $clog2(DEPTH + 1);

    arb_state_e                    state_q, state_d;
    logic                          issue_en;
    logic [NPORTS-1:0][ADDR_W-1:0] push_addr;
    logic [DEPTH-1:0]              ent_v, take;
    logic [DEPTH-1:0][ADDR_W-1:0]  ent_addr;
    logic [DEPTH-1:0][KEY_W-1:0]   ent_key;
    logic [CNT_W-1:0]              q_cnt, q_cnt_nxt;
    logic [NPORTS-1:0][IDX_W-1:0]  pidx;
    logic                          nxt_empty, nxt_tight;

    assign push_addr = in_addr;

    lkarb_queue #(
        .ADDR_W(ADDR_W), .NPORTS(NPORTS), .DEPTH(DEPTH), .CNT_W(CNT_W)
    ) u_queue (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_en  (in_ready),
        .push_v   (in_valid),
        .push_addr(push_addr),
        .take     (take),
        .ent_v    (ent_v),
        .ent_addr (ent_addr),
        .cnt      (q_cnt),
        .cnt_nxt  (q_cnt_nxt)
    );

    generate
        for (genvar e = 0; e < DEPTH; e++) begin : g_key
            lkarb_keygen #(
                .ADDR_W(ADDR_W), .KEY_W(KEY_W), .WORD_OFF(WORD_OFF),
                .LINE_OFF(LINE_OFF), .MODE(MODE)
            ) u_kg (
                .addr(ent_addr[e]),
                .key (ent_key[e])
            );
        end
    endgenerate

    lkarb_pick #(
        .NPORTS(NPORTS), .DEPTH(DEPTH), .KEY_W(KEY_W), .IDX_W(IDX_W)
    ) u_pick (
        .en  (issue_en),
        .vld (ent_v),
        .keys(ent_key),
        .take(take),
        .pv  (lk_valid),
        .pidx(pidx)
    );

    generate
        for (genvar p = 0; p < NPORTS; p++) begin : g_port
            assign lk_addr[p*ADDR_W +: ADDR_W] = lk_valid[p] ? ent_addr[pidx[p]] : '0;
            assign lk_key[p*KEY_W +: KEY_W]    = lk_valid[p] ? ent_key[pidx[p]]  : '0;
        end
    endgenerate

    // occupancy class that the coming edge will leave behind
    assign nxt_empty = (q_cnt_nxt == '0);
    assign nxt_tight = ((DEPTH - int'(q_cnt_nxt)) < NPORTS);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (nxt_tight)       state_d = ST_FULL;   // jam
                else if (!nxt_empty) state_d = ST_RUN;    // fill
            end
            ST_RUN: begin
                if (nxt_empty)       state_d = ST_IDLE;   // drain
                else if (nxt_tight)  state_d = ST_FULL;   // clog
            end
            ST_FULL: begin
                if (nxt_empty)       state_d = ST_IDLE;   // flush
                else if (!nxt_tight) state_d = ST_RUN;    // relieve
            end
            default:                 state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        in_ready = (state_q != ST_FULL);
        issue_en = (state_q != ST_IDLE);
    end
endmodule

// File: rtl/lookup_arbiter_chk.sv
module lookup_arbiter_chk #(
    parameter int NPORTS = 2,
    parameter int KEY_W  = 2,
    parameter int DEPTH  = 8,
    parameter int CNT_W  = 4
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_ready,
    input logic [NPORTS-1:0]       lk_valid,
    input logic [NPORTS*KEY_W-1:0] lk_key,
    input logic [CNT_W-1:0]        cnt,
    input lkarb_pkg::arb_state_e   state
);
    // R3: a non-empty queue always issues on port 0
    a_r3_head_issued: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |-> lk_valid[0]);

    // R1: ready only with room for a full group
    a_r1_ready_room: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> ((DEPTH - int'(cnt)) >= NPORTS));

    // R1: nothing enters while not ready
    a_r1_no_grow: assert property (@(posedge clk) disable iff (!rst_n)
        !in_ready |=> (cnt <= $past(cnt)));

    // R10: idle state means an empty queue
    a_r10_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (state == lkarb_pkg::ST_IDLE) |-> (cnt == '0));

    generate
        for (genvar p = 0; p + 1 < NPORTS; p++) begin : g_pack
            // R4: valid ports are contiguous from port 0
            a_r4_packed: assert property (@(posedge clk) disable iff (!rst_n)
                !lk_valid[p] |-> !lk_valid[p+1]);
        end
        for (genvar a = 0; a < NPORTS; a++) begin : g_pa
            for (genvar b = a + 1; b < NPORTS; b++) begin : g_pb
                // R7: same-cycle lookups never share a key
                a_r7_distinct: assert property (@(posedge clk) disable iff (!rst_n)
                    (lk_valid[a] && lk_valid[b]) |->
                    (lk_key[a*KEY_W +: KEY_W] != lk_key[b*KEY_W +: KEY_W]));
            end
        end
    endgenerate
endmodule

bind lookup_arbiter lookup_arbiter_chk #(
    .NPORTS(NPORTS), .KEY_W(KEY_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_ready(in_ready),
    .lk_valid(lk_valid),
    .lk_key  (lk_key),
    .cnt     (q_cnt),
    .state   (state_q)
);

// File: tb/sim_lookup_arbiter.sv
`timescale 1ns/1ps
module sim_lookup_arbiter;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  in_valid = '0;
    logic [63:0] in_addr = '0;
    logic        r0, r1;
    logic [1:0]  v0, v1;
    logic [63:0] a0, a1;
    logic [3:0]  k0, k1;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    lookup_arbiter #(.MODE(lkarb_pkg::ILV_BANK)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
        .in_ready(r0), .lk_valid(v0), .lk_addr(a0), .lk_key(k0));

    lookup_arbiter #(.MODE(lkarb_pkg::ILV_SET)) u1 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
        .in_ready(r1), .lk_valid(v1), .lk_addr(a1), .lk_key(k1));

    function automatic logic [1:0] bkey(logic [31:0] a); return a[3:2]; endfunction
    function automatic logic [1:0] skey(logic [31:0] a); return a[7:6]; endfunction

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // first cycle after a pair is captured
    task automatic pair_c1(string who, logic [1:0] v, logic [63:0] ad, logic [3:0] ky,
                           logic [31:0] x0, logic [31:0] x1, logic [1:0] q0, logic [1:0] q1);
        if (q0 != q1) begin
            chk({who, " R9 both ports valid"}, 64'(v), 64'd3);
            chk({who, " R4 ages on ports"}, ad, {x1, x0});
            chk({who, " key per port"}, 64'(ky), 64'({q1, q0}));
        end else begin
            chk({who, " R7 conflict holds younger"}, 64'(v), 64'd1);
            chk({who, " R2 oldest shown"}, ad[31:0], 64'(x0));
            chk({who, " key port0"}, 64'(ky[1:0]), 64'(q0));
        end
    endtask

    task automatic pair_c2(string who, logic [1:0] v, logic [63:0] ad,
                           logic [31:0] x1, logic [1:0] q0, logic [1:0] q1);
        if (q0 != q1) begin
            chk({who, " R2 gone after issue"}, 64'(v), 64'd0);
        end else begin
            chk({who, " R8 waiter next"}, 64'(v), 64'd1);
            chk({who, " R8 waiter addr"}, ad[31:0], 64'(x1));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 reset ready u0", 64'(r0), 64'd1);
        chk("R1 reset ready u1", 64'(r1), 64'd1);
        chk("R1 reset idle u0", 64'(v0), 64'd0);
        chk("R1 reset idle u1", 64'(v1), 64'd0);

        // sweep of all key pairs, both modes at once (R5, R6, R7, R9)
        for (int b0 = 0; b0 < 4; b0++)
        for (int b1 = 0; b1 < 4; b1++)
        for (int s0 = 0; s0 < 4; s0++)
        for (int s1 = 0; s1 < 4; s1++) begin
            logic [31:0] x0, x1;
            x0 = 32'h1000 * (b0 * 64 + b1 * 16 + s0 * 4 + s1) | 32'(s0 << 6) | 32'(b0 << 2) | 32'h10;
            x1 = 32'h5000 + 32'h1000 * (b1 + s1) | 32'(s1 << 6) | 32'(b1 << 2) | 32'h21;
            in_valid = 2'b11;
            in_addr  = {x1, x0};
            @(negedge clk);
            in_valid = '0;
            pair_c1("u0 R5", v0, a0, k0, x0, x1, bkey(x0), bkey(x1));
            pair_c1("u1 R6", v1, a1, k1, x0, x1, skey(x0), skey(x1));
            @(negedge clk);
            pair_c2("u0", v0, a0, x1, bkey(x0), bkey(x1));
            pair_c2("u1", v1, a1, x1, skey(x0), skey(x1));
            @(negedge clk);
            chk("R8 u0 empty after pair", 64'(v0), 64'd0);
            chk("R8 u1 empty after pair", 64'(v1), 64'd0);
        end

        // R9 line-crossing fetch: 0x3C and 0x40 differ in both keys
        in_valid = 2'b11;
        in_addr  = {32'h0000_0040, 32'h0000_003C};
        @(negedge clk);
        in_valid = '0;
        chk("R9 u0 split fetch parallel", 64'(v0), 64'd3);
        chk("R9 u1 split fetch parallel", 64'(v1), 64'd3);
        @(negedge clk);

        // R7 younger free key passes a blocked one (bank mode)
        in_valid = 2'b11;
        in_addr  = {32'h0000_0100, 32'h0000_0000};
        @(negedge clk);
        chk("R7 u0 only A", 64'(v0), 64'd1);
        chk("R3 u0 A on port0", a0[31:0], 64'h0);
        in_addr  = {32'h0000_0304, 32'h0000_0200};
        @(negedge clk);
        in_valid = '0;
        chk("R7 u0 B and D", 64'(v0), 64'd3);
        chk("R7 u0 B then D", a0, {32'h0000_0304, 32'h0000_0100});
        @(negedge clk);
        chk("R8 u0 C last", 64'(v0), 64'd1);
        chk("R8 u0 C addr", a0[31:0], 64'h200);
        repeat (4) @(negedge clk);
        chk("R8 u0 drained", 64'(v0), 64'd0);
        chk("R8 u1 drained", 64'(v1), 64'd0);

        // all-conflict stream fills the queue (R1, R3, R8, R10)
        begin
            int c = 0, s = 0, head = 0;
            bit p;
            for (int cyc = 0; cyc < 26; cyc++) begin
                chk("R1/R10 u0 ready", 64'(r0), 64'((8 - c) >= 2));
                chk("R1/R10 u1 ready", 64'(r1), 64'((8 - c) >= 2));
                chk("R3 u0 head valid", 64'(v0), 64'(c > 0));
                chk("R3 u1 head valid", 64'(v1), 64'(c > 0));
                if (c > 0) begin
                    chk("R8 u0 order", a0[31:0], 64'(head << 8));
                    chk("R8 u1 order", a1[31:0], 64'(head << 8));
                end
                p = ((8 - c) >= 2) && (s < 16);
                in_valid = p ? 2'b11 : 2'b00;
                in_addr  = {32'((s + 1) << 8), 32'(s << 8)};
                if (p) s += 2;
                if (c > 0) begin head++; c--; end
                if (p) c += 2;
                @(negedge clk);
            end
            in_valid = '0;
            chk("R8 all issued", 64'(head), 64'd16);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule